// File: doc/BRIEF.md
# Interleaved Switching Clock Controller

This block decides which role a step-down regulator controller plays and produces the tick that starts each PWM switching cycle. A two-bit digitized enable level picks the role: off, master or slave. A separate strap input reports that the sync line is tied to ground, which selects single-device operation on the internal time base. As master, the block times its cycles from an internal divider and drives a sync clock four times the switching rate to a partner device. As slave, it counts the partner's sync pulses and starts its own cycle two sync periods after the pulse it takes as count zero. Its cycles therefore land half a switching period away from the master's.

The internal time base divides the system clock by `SYNC_DIV` per sync period. One switching period is four sync periods. Light-load skip operation stays permitted in every enabled role. If a slave stops seeing sync pulses, it falls back to the internal divider and raises a loss flag until pulses return. A change of role waits for the end of the running switching cycle, so no cycle is cut short.

Top module: `ilv_clk_ctrl`

## Requirements
- R1: After reset, `role_o` is 2'b00 (off) and `tick_o`, `sync_o`, `sync_oe_o`, `sync_lost_o` and `skip_ok_o` are all 0.
- R2: The requested role decodes as follows. `en_level` 2'b00 is off (code 2'b00). 2'b01 is master (code 2'b01). 2'b10 and 2'b11 are slave (code 2'b10). If `sync_gnd` is 1 and `en_level` is not 2'b00, the role is single (code 2'b11). While off, `tick_o` stays 0.
- R3: As master, `tick_o` repeats every 4*`SYNC_DIV` clocks. `sync_o` rises four times per switching period, stays high `PULSE_W` clocks each time, and is high in the cycle where `tick_o` is high. `sync_oe_o` is 1 only in the master role. Levels on `sync_in` have no effect.
- R4: In the single role, `tick_o` repeats every 4*`SYNC_DIV` clocks, `sync_o` stays 0 and `sync_in` is ignored.
- R5: As slave, every rising edge of `sync_in` advances a count modulo 4. The count starts at 0 with the first rise after the slave role begins. `tick_o` pulses for the rise that carries count 2. The pulse is high in the cycle after the third rising clock edge that samples `sync_in` high for that rise. This places slave cycle starts half a switching period after rises numbered 0 mod 4.
- R6: As slave, if no rise of `sync_in` follows a rise within 2*`SYNC_DIV` clocks, `sync_lost_o` becomes 1 and ticks come from the internal divider. The next rise clears `sync_lost_o` and counts as 0.
- R7: A role change from off takes effect on the next clock. Any other role change (including to off) takes effect only in the cycle where `tick_o` is high.
- R8: `skip_ok_o` is 1 whenever the role is not off.
- R9: `tick_o` is high for exactly one clock per switching cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_level | input | 2 | Digitized enable level: off, master or slave |
| sync_gnd | input | 1 | Strap: sync line tied low, single-device operation |
| sync_in | input | 1 | Sync line as seen by the device (asynchronous) |
| role_o | output | 2 | Active role: 00 off, 01 master, 10 slave, 11 single |
| tick_o | output | 1 | One-clock PWM cycle-start pulse |
| sync_o | output | 1 | Sync clock driven to the partner in master role |
| sync_oe_o | output | 1 | Output enable for the sync driver |
| sync_lost_o | output | 1 | Slave has lost the sync clock |
| skip_ok_o | output | 1 | Light-load skip operation permitted |

## Verification
The bench builds the block with `SYNC_DIV` = 8 and `PULSE_W` = 3, so a switching period is 32 clocks and the loss window is 16 clocks. Its own sync generator runs with a 10-clock period, which gives a slave period of 40 clocks. That makes locked slave operation easy to tell apart from the 32-clock internal fallback. The short periods let the bench cover every role, the deferred role changes, the exact first-tick cycle after lock, and the exact loss cycle in a few thousand clocks.

// File: rtl/ilv_clk_ctrl.sv
`timescale 1ns/1ps
module ilv_clk_ctrl #(
  parameter int SYNC_DIV = 42,
  parameter int PULSE_W  = 21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] en_level,
  input  logic       sync_gnd,
  input  logic       sync_in,
  output logic [1:0] role_o,
  output logic       tick_o,
  output logic       sync_o,
  output logic       sync_oe_o,
  output logic       sync_lost_o,
  output logic       skip_ok_o
);
  localparam int PH_W = $clog2(SYNC_DIV);
  localparam int LIM  = 2 * SYNC_DIV;
  localparam int WD_W = $clog2(LIM + 1);
  localparam logic [1:0] OFF = 2'b00, MST = 2'b01, SLV = 2'b10, SGL = 2'b11;

  logic [1:0]      role_q, req;
  logic [PH_W-1:0] ph;
  logic [1:0]      qtr, ecnt;
  logic [WD_W-1:0] wd;
  logic            s1, s2, s3, lost, tick_q;
  logic            rise, src_int, fire_int, fire_slv, fire, ph_last;

  assign req = (en_level == 2'b00) ? OFF :
               sync_gnd            ? SGL :
               en_level[1]         ? SLV : MST;

  assign rise     = s2 & ~s3;
  assign ph_last  = (ph == PH_W'(SYNC_DIV - 1));
  assign src_int  = (role_q == MST) || (role_q == SGL) || (role_q == SLV && lost);
  assign fire_int = src_int && ph_last && (qtr == 2'd3);
  assign fire_slv = (role_q == SLV) && !lost && rise && (ecnt == 2'd2);
  assign fire     = fire_int || fire_slv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role_q <= OFF;
      ph     <= '0;
      qtr    <= '0;
      s1     <= 1'b0;
      s2     <= 1'b0;
      s3     <= 1'b0;
      ecnt   <= '0;
      wd     <= '0;
      lost   <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      s1     <= sync_in;
      s2     <= s1;
      s3     <= s2;
      tick_q <= fire;

      if (role_q == OFF || fire) role_q <= req;

      if (role_q == OFF || fire) begin
        ph  <= '0;
        qtr <= '0;
      end else if (ph_last) begin
        ph  <= '0;
        qtr <= qtr + 2'd1;
      end else begin
        ph <= ph + PH_W'(1);
      end

      if (role_q != SLV) begin
        ecnt <= '0;
        wd   <= '0;
        lost <= 1'b0;
      end else if (rise) begin
        wd   <= '0;
        lost <= 1'b0;
        ecnt <= lost ? 2'd1 : ecnt + 2'd1;
      end else begin
        if (wd != WD_W'(LIM)) wd <= wd + WD_W'(1);
        if (wd == WD_W'(LIM - 1)) lost <= 1'b1;
      end
    end
  end

  assign role_o      = role_q;
  assign tick_o      = tick_q;
  assign sync_o      = (role_q == MST) && (ph < PH_W'(PULSE_W));
  assign sync_oe_o   = (role_q == MST);
  assign sync_lost_o = lost;
  assign skip_ok_o   = (role_q != OFF);

  assert_no_tick_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (role_q == OFF && $past(role_q) == OFF) |-> !tick_o);

  assert_sync_edge_at_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && role_q == MST && $past(role_q) == MST) |-> sync_o);

  assert_loss_only_as_slave_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_lost_o) |-> (role_q == SLV));

  assert_role_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (role_q != $past(role_q) && $past(role_q) != OFF) |-> tick_o);

  assert_tick_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: tb/ilv_clk_ctrl_test.sv
`timescale 1ns/1ps
module ilv_clk_ctrl_test;
  localparam int SD = 8;
  localparam int PW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] en_level = 2'b00;
  logic sync_gnd = 1'b0, sync_in = 1'b0;
  logic [1:0] role_o;
  logic tick_o, sync_o, sync_oe_o, sync_lost_o, skip_ok_o;

  int checks = 0, fails = 0;
  int gp = 10, gc = 9;
  logic gen_on = 1'b0;

  ilv_clk_ctrl #(.SYNC_DIV(SD), .PULSE_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .en_level(en_level), .sync_gnd(sync_gnd),
    .sync_in(sync_in), .role_o(role_o), .tick_o(tick_o), .sync_o(sync_o),
    .sync_oe_o(sync_oe_o), .sync_lost_o(sync_lost_o), .skip_ok_o(skip_ok_o));

  always #10 clk = ~clk;

  // {en[18:17], gnd[16], gen[15], role[14:13], period[12:5], syncs[4:2], lost[1], oe[0]}
  localparam logic [18:0] VEC [7] = '{
    {2'b01, 1'b0, 1'b0, 2'b01, 8'd32, 3'd4, 1'b0, 1'b1},
    {2'b10, 1'b0, 1'b1, 2'b10, 8'd40, 3'd0, 1'b0, 1'b0},
    {2'b10, 1'b0, 1'b0, 2'b10, 8'd32, 3'd0, 1'b1, 1'b0},
    {2'b01, 1'b1, 1'b0, 2'b11, 8'd32, 3'd0, 1'b0, 1'b0},
    {2'b11, 1'b1, 1'b1, 2'b11, 8'd32, 3'd0, 1'b0, 1'b0},
    {2'b11, 1'b0, 1'b1, 2'b10, 8'd40, 3'd0, 1'b0, 1'b0},
    {2'b01, 1'b0, 1'b1, 2'b01, 8'd32, 3'd4, 1'b0, 1'b1}
  };

  initial forever begin
    @(negedge clk);
    if (gen_on) begin
      gc = (gc >= gp - 1) ? 0 : gc + 1;
      sync_in = (gc < 3);
    end else begin
      gc = gp - 1;
      sync_in = 1'b0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_tick(output int n, output int rises);
    logic prev;
    n = 0; rises = 0; prev = sync_o;
    do begin
      @(negedge clk);
      n++;
      if (sync_o && !prev) rises++;
      prev = sync_o;
    end while (!tick_o && n < 400);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual hung, expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n, r;
    repeat (3) @(negedge clk);
    check("R1 role", role_o, 0);
    check("R1 outputs", {tick_o, sync_o, sync_oe_o, sync_lost_o, skip_ok_o}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 off no tick", tick_o, 0);

    for (int i = 0; i < 7; i++) begin
      en_level = VEC[i][18:17];
      sync_gnd = VEC[i][16];
      gen_on   = VEC[i][15];
      repeat (3) wait_tick(n, r);
      wait_tick(n, r);
      check("R2 role decode", role_o, int'(VEC[i][14:13]));
      check("R3/R4/R5 tick period", n, int'(VEC[i][12:5]));
      check("R3/R4 sync pulses per period", r, int'(VEC[i][4:2]));
      check("R6 loss flag", sync_lost_o, int'(VEC[i][1]));
      check("R3 sync output enable", sync_oe_o, int'(VEC[i][0]));
      check("R8 skip permitted", skip_ok_o, 1);
      @(negedge clk);
      check("R9 tick single cycle", tick_o, 0);
    end

    // R7: going off waits for the cycle boundary
    gen_on = 1'b0;
    en_level = 2'b00;
    sync_gnd = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (role_o != 2'b00 && n < 100);
    check("R7 off at boundary cycles", n, 32 - 1);
    check("R7 off with tick", tick_o, 1);
    r = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      r += int'(tick_o) + int'(sync_o);
    end
    check("R2 off quiet", r, 0);
    check("R8 skip when off", skip_ok_o, 0);

    // R7 immediate from off, R5 first slave tick position
    en_level = 2'b10;
    @(negedge clk);
    check("R7 immediate from off", role_o, 2);
    @(posedge clk); #1 gen_on = 1'b1;
    @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_o && n < 60);
    check("R5 first slave tick", n, 2 * 10 + 3);

    // R6 loss timing after last rise
    do @(posedge clk); while (gc != 0);
    #1 gen_on = 1'b0;
    for (int k = 1; k <= 19; k++) begin
      @(negedge clk);
      if (k == 18) check("R6 not yet lost", sync_lost_o, 0);
      if (k == 19) check("R6 lost at limit", sync_lost_o, 1);
    end
    wait_tick(n, r);
    wait_tick(n, r);
    check("R6 fallback period", n, 32);

    // R6 relock clears flag
    @(posedge clk); #1 gen_on = 1'b1;
    @(negedge clk);
    repeat (2) @(negedge clk);
    check("R6 still flagged before sync", sync_lost_o, 1);
    @(negedge clk);
    check("R6 cleared on rise", sync_lost_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule